// File: doc/BRIEF.md
# QPSK Square-Wave Phase Demodulator

This block takes a one-bit, digitally generated QPSK signal and returns the dibits it carries. Each symbol is a 50 % duty square carrier that lasts one carrier period. The four symbols differ only by a shift of a whole quarter period. An internal counter, assumed to be aligned with the transmitter's counter, splits each period into four quarters of `QUARTER_CLKS` clocks each. One sample is taken in each quarter. If that sample is low, a fixed weight for the quarter is added to a running sum. If it is high, nothing is added.

When the period closes, the sum is decoded to a dibit. The dibit appears in parallel on `dibit_out`. It is also sent serially, high bit first. A sum that matches no carrier is reported on `sym_err` and does not change the held dibit. The `start` input gates everything. While it is low, the timing is held at the start of a period and nothing is emitted.

Top module: `qpsk_sqdemod`

## Requirements
- R1: While reset (`rst_n` low) is applied, the next cycle shows `ser_valid`=0, `sym_err`=0, `ser_bit`=0 and `dibit_out`=2'b00.
- R2: While `start` is low, `ser_valid` and `sym_err` stay low. The period timing is held so that the first cycle in which `start` is high is clock 0 of quarter 0.
- R3: Each quarter q (0..3) is sampled once, at clock `QUARTER_CLKS/2` within the quarter. A low sample adds a weight of 1, 1, 2 or 3 for quarter 0, 1, 2 or 3. A high sample adds 0.
- R4: The sum decodes as 5→2'b00, 3→2'b01, 2→2'b10 and 4→2'b11. The matching carriers are low in these quarters: 00 in quarters 2 and 3, 01 in quarters 1 and 2, 10 in quarters 0 and 1, 11 in quarters 3 and 0.
- R5: A valid symbol updates `dibit_out` at the clock edge that ends its period. In the next cycle, `ser_valid` pulses with `ser_bit` equal to the high bit of the dibit.
- R6: The low bit follows 2·`QUARTER_CLKS` cycles after the high bit, with its own one-cycle `ser_valid` pulse. `ser_bit` holds each bit between pulses.
- R7: Any other sum (0, 1, 6 or 7) pulses `sym_err` for one cycle, in the cycle where a high bit would have appeared. In that case `dibit_out` keeps its previous value and no `ser_valid` pulse follows.
- R8: The sum is cleared at every period boundary, so each symbol in a back-to-back stream decodes on its own.
- R9: Dropping `start` in the middle of a period discards the partial symbol and any bit not yet sent. Raising `start` again begins a fresh period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Demodulation enable |
| mod_in | input | 1 | Square-wave QPSK signal |
| dibit_out | output | 2 | Last valid decoded dibit |
| ser_bit | output | 1 | Serial data, high bit first |
| ser_valid | output | 1 | One-cycle strobe marking a new serial bit |
| sym_err | output | 1 | One-cycle pulse for an undecodable period |

## Verification
The bench feeds all four carriers in a stream of back-to-back symbols. A design that failed to clear the sum at each boundary would decode the later symbols wrongly. It also sends the undecodable sums 0, 7 and 1. A design that decoded these anyway, or overwrote the held dibit, is caught by the `sym_err` and `dibit_out` checks. Every serial strobe is compared against the cycle in which it is due, so an off-by-one in latching or in the half-symbol hold would show up. Finally, `start` is dropped in the middle of a symbol and then raised again. Any output during the idle gap is reported, and so is a misaligned restart.

// File: rtl/qpsk_sqdemod_pkg.sv
// Shared types and the weight and decode rules for the square-wave QPSK demodulator.
package qpsk_sqdemod_pkg;

    typedef logic [1:0] dibit_t;
    typedef logic [2:0] wsum_t;

    typedef struct packed {
        logic   ok;
        dibit_t val;
    } decode_t;

    // Weight that a low sample in quarter qi contributes.
    function automatic wsum_t quarter_weight(input logic [1:0] qi);
        case (qi)
            2'd0:    return 3'd1;
            2'd1:    return 3'd1;
            2'd2:    return 3'd2;
            default: return 3'd3;
        endcase
    endfunction

    // Map a period sum onto a dibit; sums no carrier can produce are flagged.
    function automatic decode_t decode_sum(input wsum_t s);
        decode_t d;
        d.ok  = 1'b1;
        d.val = 2'b00;
        case (s)
            3'd5:    d.val = 2'b00;
            3'd3:    d.val = 2'b01;
            3'd2:    d.val = 2'b10;
            3'd4:    d.val = 2'b11;
            default: d.ok  = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/qsd_phase_cnt.sv
// Period timing. It counts clocks within a quarter and quarters within a period.
// It marks the one sampling clock of each quarter and the last clock of the period.
// Assumes the transmitter's period starts on the first cycle in which start is high.
module qsd_phase_cnt #(
    parameter int QUARTER_CLKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output logic [1:0] quarter_idx,
    output logic       sample_hit,
    output logic       period_end
);
    localparam int SUB_W      = (QUARTER_CLKS > 1) ? $clog2(QUARTER_CLKS) : 1;
    localparam int SAMPLE_POS = QUARTER_CLKS / 2;

    logic sub_last;

    generate
        if (QUARTER_CLKS == 1) begin : g_single
            // One clock per quarter: every clock samples and ends its quarter.
            assign sub_last   = 1'b1;
            assign sample_hit = 1'b1;
        end else begin : g_multi
            logic [SUB_W-1:0] sub_cnt;

            // Clock-within-quarter counter, held at zero while idle.
            always_ff @(posedge clk) begin
                if (!rst_n || !start) begin
                    sub_cnt <= '0;
                end else if (sub_cnt == SUB_W'(QUARTER_CLKS - 1)) begin
                    sub_cnt <= '0;
                end else begin
                    sub_cnt <= sub_cnt + 1'b1;
                end
            end

            assign sub_last   = (sub_cnt == SUB_W'(QUARTER_CLKS - 1));
            assign sample_hit = (sub_cnt == SUB_W'(SAMPLE_POS));
        end
    endgenerate

    // Quarter index, stepping at the last clock of each quarter.
    always_ff @(posedge clk) begin
        if (!rst_n || !start) begin
            quarter_idx <= 2'd0;
        end else if (sub_last) begin
            quarter_idx <= quarter_idx + 2'd1;
        end
    end

    assign period_end = sub_last && (quarter_idx == 2'd3);

endmodule

// File: rtl/qsd_accum.sv
// Weighted low-level accumulator. It adds the quarter weight for each low sample.
// It offers the period's running total, including the current clock's addition.
// The total is cleared after the period boundary and while idle.
module qsd_accum
    import qpsk_sqdemod_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       mod_in,
    input  logic       sample_hit,
    input  logic [1:0] quarter_idx,
    input  logic       period_end,
    output wsum_t      sum_now
);
    wsum_t acc;
    wsum_t add_w;

    // Weight contributed on this clock, zero for high samples or non-sample clocks.
    always_comb begin
        add_w = '0;
        if (sample_hit && !mod_in) begin
            add_w = quarter_weight(quarter_idx);
        end
    end

    assign sum_now = acc + add_w;

    // Running sum, restarted at each period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !start || period_end) begin
            acc <= '0;
        end else begin
            acc <= sum_now;
        end
    end

endmodule

// File: rtl/qsd_decode_latch.sv
// Decodes the period sum at the boundary and holds the last valid dibit.
// An undecodable sum gives a one-cycle error pulse and leaves the held dibit alone.
module qsd_decode_latch
    import qpsk_sqdemod_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   period_end,
    input  wsum_t  sum_now,
    output dibit_t dibit_q,
    output logic   err_q,
    output logic   load_en,
    output dibit_t load_val
);
    decode_t dec;

    // Combinational decode of the total that closes the period.
    always_comb begin
        dec = decode_sum(sum_now);
    end

    assign load_en  = start && period_end && dec.ok;
    assign load_val = dec.val;

    // Held dibit and error strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dibit_q <= 2'b00;
            err_q   <= 1'b0;
        end else begin
            err_q <= start && period_end && !dec.ok;
            if (load_en) begin
                dibit_q <= dec.val;
            end
        end
    end

endmodule

// File: rtl/qsd_serializer.sv
// Parallel-to-serial stage. It sends the high bit at load and the low bit HOLD_CLKS later.
// Each new bit gets a one-cycle valid strobe. Assumes loads are at least HOLD_CLKS+1 apart.
module qsd_serializer
    import qpsk_sqdemod_pkg::*;
#(
    parameter int HOLD_CLKS = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   load_en,
    input  dibit_t load_val,
    output logic   ser_bit,
    output logic   ser_valid
);
    localparam int CNT_W = (HOLD_CLKS > 1) ? $clog2(HOLD_CLKS) : 1;

    logic             lo_bit;
    logic             lo_pending;
    logic [CNT_W-1:0] hold_cnt;

    // Bit sequencing with the half-symbol hold timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_bit    <= 1'b0;
            ser_valid  <= 1'b0;
            lo_bit     <= 1'b0;
            lo_pending <= 1'b0;
            hold_cnt   <= '0;
        end else if (!start) begin
            ser_valid  <= 1'b0;
            lo_pending <= 1'b0;
            hold_cnt   <= '0;
        end else if (load_en) begin
            ser_bit    <= load_val[1];
            lo_bit     <= load_val[0];
            ser_valid  <= 1'b1;
            lo_pending <= 1'b1;
            hold_cnt   <= '0;
        end else begin
            ser_valid <= 1'b0;
            if (lo_pending) begin
                if (hold_cnt == CNT_W'(HOLD_CLKS - 1)) begin
                    ser_bit    <= lo_bit;
                    ser_valid  <= 1'b1;
                    lo_pending <= 1'b0;
                end else begin
                    hold_cnt <= hold_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/qpsk_sqdemod.sv
// Top of the square-wave QPSK demodulator: timing, weighted sum, decode and serial output.
// Assumes mod_in is phase-aligned with the internal period count from the rise of start.
module qpsk_sqdemod
    import qpsk_sqdemod_pkg::*;
#(
    parameter int QUARTER_CLKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       mod_in,
    output logic [1:0] dibit_out,
    output logic       ser_bit,
    output logic       ser_valid,
    output logic       sym_err
);
    localparam int HOLD_CLKS = 2 * QUARTER_CLKS;

    logic [1:0] quarter_idx;
    logic       sample_hit;
    logic       period_end;
    wsum_t      sum_now;
    logic       load_en;
    dibit_t     load_val;

    qsd_phase_cnt #(.QUARTER_CLKS(QUARTER_CLKS)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .quarter_idx (quarter_idx),
        .sample_hit  (sample_hit),
        .period_end  (period_end)
    );

    qsd_accum u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .mod_in      (mod_in),
        .sample_hit  (sample_hit),
        .quarter_idx (quarter_idx),
        .period_end  (period_end),
        .sum_now     (sum_now)
    );

    qsd_decode_latch u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .period_end (period_end),
        .sum_now    (sum_now),
        .dibit_q    (dibit_out),
        .err_q      (sym_err),
        .load_en    (load_en),
        .load_val   (load_val)
    );

    qsd_serializer #(.HOLD_CLKS(HOLD_CLKS)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .load_en   (load_en),
        .load_val  (load_val),
        .ser_bit   (ser_bit),
        .ser_valid (ser_valid)
    );

endmodule

// File: rtl/qpsk_sqdemod_chk.sv
// Port-level properties of the demodulator, attached to every instance by bind.
module qpsk_sqdemod_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [1:0] dibit_out,
    input logic       ser_bit,
    input logic       ser_valid,
    input logic       sym_err
);
    // R1: reset leaves the outputs quiet with a cleared dibit.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!ser_valid && !sym_err && dibit_out == 2'b00));

    // R2: a cycle after start was low, no strobe of either kind.
    a_r2_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(start) |-> (!ser_valid && !sym_err));

    // R5: a new held dibit is announced with its high bit.
    a_r5_new_dibit_hi_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (dibit_out != $past(dibit_out)) |-> (ser_valid && ser_bit == dibit_out[1]));

    // R6: serial strobes last one cycle.
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid |=> !ser_valid);

    // R7: an error never comes with data, and the held dibit stays.
    a_r7_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        sym_err |-> (!ser_valid && $stable(dibit_out)));

    // R7: the error strobe is one cycle long.
    a_r7_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        sym_err |=> !sym_err);

endmodule

bind qpsk_sqdemod qpsk_sqdemod_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dibit_out (dibit_out),
    .ser_bit   (ser_bit),
    .ser_valid (ser_valid),
    .sym_err   (sym_err)
);

// File: tb/qpsk_sqdemod_tb_top.sv
// Scoreboard bench: the driver queues expected strobes, the monitor matches them on the falling edge.
module qpsk_sqdemod_tb_top;

    localparam int QC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       mod_in = 1'b1;
    logic [1:0] dibit_out;
    logic       ser_bit;
    logic       ser_valid;
    logic       sym_err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [1:0] last_good = 2'b00;

    typedef struct {
        bit         is_err;
        bit         val;
        logic [1:0] held;
        int         due;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    qpsk_sqdemod #(.QUARTER_CLKS(QC)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mod_in    (mod_in),
        .dibit_out (dibit_out),
        .ser_bit   (ser_bit),
        .ser_valid (ser_valid),
        .sym_err   (sym_err)
    );

    // Bench model of R3/R4: sum of the weights over the low quarters, then the sum table.
    function automatic int model_sum(input logic [3:0] lowq);
        int w[4] = '{1, 1, 2, 3};
        int s = 0;
        for (int i = 0; i < 4; i++) if (lowq[i]) s += w[i];
        return s;
    endfunction

    function automatic logic [3:0] carrier_of(input logic [1:0] d);
        case (d)
            2'b00:   return 4'b1100;
            2'b01:   return 4'b0110;
            2'b10:   return 4'b0011;
            default: return 4'b1001;
        endcase
    endfunction

    // Drive one period whose low quarters are lowq, and queue the expected strobes.
    task automatic send_period(input logic [3:0] lowq, input int nclk);
        int s;
        int c0;
        exp_t e;
        s  = model_sum(lowq);
        c0 = cyc;
        if (nclk == 4 * QC) begin
            if (s == 5 || s == 3 || s == 2 || s == 4) begin
                logic [1:0] d;
                d = (s == 5) ? 2'b00 : (s == 3) ? 2'b01 : (s == 2) ? 2'b10 : 2'b11;
                e.is_err = 0; e.val = d[1]; e.held = d; e.due = c0 + 4 * QC;
                sb.push_back(e);
                e.val = d[0]; e.due = c0 + 6 * QC;
                sb.push_back(e);
                last_good = d;
            end else begin
                e.is_err = 1; e.val = 0; e.held = last_good; e.due = c0 + 4 * QC;
                sb.push_back(e);
            end
        end
        for (int k = 0; k < nclk; k++) begin
            mod_in = !lowq[k / QC];
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Monitor: every strobe must match the head of the scoreboard in value and cycle.
    always @(negedge clk) begin
        if (rst_n && (ser_valid || sym_err)) begin
            if (sb.size() == 0) begin
                check(0, "R2/R9 unexpected strobe", {ser_valid, sym_err}, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.is_err) begin
                    check(sym_err && !ser_valid, "R7 error strobe", {ser_valid, sym_err}, 1);
                    check(dibit_out == e.held, "R7 dibit held on error", dibit_out, e.held);
                    check(cyc == e.due, "R7 error timing", cyc, e.due);
                end else begin
                    check(ser_valid && !sym_err, "R6 data strobe", {ser_valid, sym_err}, 2);
                    check(ser_bit == e.val, "R4/R6 serial bit", ser_bit, e.val);
                    check(cyc == e.due, "R5/R6 strobe timing", cyc, e.due);
                    check(dibit_out == e.held, "R5 parallel dibit", dibit_out, e.held);
                end
            end
        end
    end

    task automatic run_all();
        logic [1:0] stream[10] = '{2'b10, 2'b11, 2'b00, 2'b01, 2'b10,
                                   2'b11, 2'b10, 2'b00, 2'b00, 2'b00};
        repeat (4) @(posedge clk);
        #1;
        @(negedge clk);
        // R1: outputs while reset is applied
        check(!ser_valid && !sym_err && !ser_bit && dibit_out == 2'b00,
              "R1 reset state", {dibit_out, ser_bit, ser_valid, sym_err}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        // R2: toggle the input with start low; nothing may come out
        for (int k = 0; k < 12; k++) begin
            mod_in = k[1];
            @(posedge clk); #1;
        end
        // R4/R8: stream of back-to-back symbols covering every carrier
        start = 1'b1;
        foreach (stream[i]) send_period(carrier_of(stream[i]), 4 * QC);
        // R7: undecodable sums 0, 7 and 1, interleaved with valid symbols
        send_period(4'b0000, 4 * QC);
        send_period(carrier_of(2'b01), 4 * QC);
        send_period(4'b1111, 4 * QC);
        send_period(4'b0001, 4 * QC);
        send_period(carrier_of(2'b11), 4 * QC);
        // R9: abandon a partial symbol, idle, then restart aligned
        send_period(4'b1111, 3 * QC);
        start = 1'b0;
        for (int k = 0; k < 10; k++) begin
            mod_in = k[0];
            @(posedge clk); #1;
        end
        start = 1'b1;
        send_period(carrier_of(2'b00), 4 * QC);
        send_period(carrier_of(2'b10), 4 * QC);
        send_period(carrier_of(2'b01), 4 * QC);
        mod_in = 1'b1;
        repeat (3 * QC) @(posedge clk);
        #1;
        start = 1'b0;
        repeat (20) @(posedge clk);
        @(negedge clk);
        // R9/R5: every queued strobe arrived
        check(sb.size() == 0, "R5 all expected strobes seen", sb.size(), 0);
        // R7: last valid symbol still held after the idle tail
        check(dibit_out == 2'b01, "R7 final held dibit", dibit_out, 1);
    endtask

    initial begin
        bit timed_out = 0;
        fork
            run_all();
            begin
                repeat (200000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) check(0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule